// File: doc/BRIEF.md
# Synchronous Tag RAM with Compare

This block is a small synchronous tag store for a cache controller. Besides plain reads and writes it can compare a word on the data bus with the word held at the addressed location and report the result on a dedicated match output. It can also do a fill write, which stores the last compared word into a location without taking anything from the bus. A controller uses it to look up a tag with a compare cycle. On a miss it refills the line and then updates the tag with a fill write, so it does not have to drive the tag a second time.

All inputs except the two output enables are sampled on the rising clock edge. The bus is modelled as a separate input, output and output-enable. The match output has its own drive enable. Both drive enables are gated without a clock by the data output enable and the match output enable. The array holds 16 words of 18 bits. Each word is split into two 9-bit byte lanes.

Top module: `tagram_cmp`

## Requirements
- R1: The block is selected only when `ce1_n`=0, `ce2_n`=0 and `ce3`=1. Any other combination neither writes nor reads. With `moe_n` low, the cycle after it drives `match_o`=1 with `match_oe`=1 and `dq_oe`=0.
- R2: Write lanes are qualified as follows. Lane 0 is bits 8:0 and lane 1 is bits 17:9. When `gw_n`=0, both lanes are written. When `bwe_n`=0, each lane whose `bw_n` bit is 0 is written. When neither applies, the cycle is not a write and leaves the memory unchanged.
- R3: A selected cycle with no write and `oe_n` low at the edge puts the stored word on `dq_o` after that edge, with `dq_oe`=1.
- R4: A selected write with `din_en_n`=0 stores `dq_i` in the enabled lanes. A following read of the same address returns it.
- R5: A selected write with `din_en_n`=1 is a fill write. It stores the latched compare word in the enabled lanes, and `dq_oe` is 0 after it.
- R6: A selected cycle with no write, `din_en_n`=0 and `oe_n`=1 is a compare cycle. After the edge, `match_o` is 1 when all 18 bits of `dq_i` equal the stored word and 0 otherwise. It is driven (`match_oe`=1) only while `moe_n` is low. In a read cycle, `match_oe` stays 0.
- R7: After a deselected edge, `dq_oe`=0 and `match_o`=1. `match_oe` follows `moe_n` inverted.
- R8: `oe_n` and `moe_n` act without a clock. Raising either turns off its drive enable at once. Lowering it again restores the drive enable.
- R9: While reset (`rst`, synchronous, active high) is applied, and after it, `dq_oe`=0 and `match_oe`=0 whatever `oe_n` and `moe_n` do. Reset clears every word and the compare word to 0.
- R10: The compare word is loaded only by compare cycles. Normal writes and reads in between do not change what a later fill write stores.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 4 | Word address |
| ce1_n | input | 1 | Chip enable, active low |
| ce2_n | input | 1 | Chip enable, active low |
| ce3 | input | 1 | Chip enable, active high |
| gw_n | input | 1 | Global write, active low, all lanes |
| bwe_n | input | 1 | Byte write enable, active low |
| bw_n | input | 2 | Per-lane write selects, active low |
| din_en_n | input | 1 | Data-input enable, active low (high on a write selects fill) |
| oe_n | input | 1 | Asynchronous data output enable, active low |
| moe_n | input | 1 | Asynchronous match output enable, active low |
| dq_i | input | 18 | Bus data into the block |
| dq_o | output | 18 | Bus data out of the block |
| dq_oe | output | 1 | Bus drive enable |
| match_o | output | 1 | Compare result, high on equal or when deselected |
| match_oe | output | 1 | Match drive enable |

## Verification
The hardest state to reach from the ports is a fill write whose stored value proves where it came from. The compare word is hidden, so the bench has to expose it through a later read. To do this, the bench runs a compare with a distinctive word against a location that mismatches. It then does an unrelated normal write and a read, and only then a full fill and a one-lane fill into locations known to hold zero. Reading those locations back shows that only the compare cycle loaded the word, and that the lane mask applies to fills too. The bench reaches the asynchronous enable behaviour by holding a read or a compare steady across clock edges while it toggles `oe_n` and `moe_n` between edges.

// File: rtl/tagram_pkg.sv
package tagram_pkg;
    localparam int ADDR_W_DEF = 4;
    localparam int LANE_W_DEF = 9;
    localparam int LANES_DEF  = 2;

    // cycle kind decided at the clock edge
    typedef enum logic [2:0] {
        OP_READ,
        OP_COMPARE,
        OP_WRITE,
        OP_FILL,
        OP_DESEL
    } op_e;

    // what the registered output stage presents after the edge
    typedef enum logic [1:0] {
        OUT_NONE,
        OUT_READ,
        OUT_MATCH,
        OUT_DESEL
    } out_e;

    function automatic logic chip_selected(input logic e1_n, input logic e2_n, input logic e3);
        return !e1_n && !e2_n && e3;
    endfunction
endpackage

// File: rtl/tagram_decode.sv
module tagram_decode
    import tagram_pkg::*;
#(
    parameter int LANES = LANES_DEF
) (
    input  logic             ce1_n,
    input  logic             ce2_n,
    input  logic             ce3,
    input  logic             gw_n,
    input  logic             bwe_n,
    input  logic [LANES-1:0] bw_n,
    input  logic             din_en_n,
    input  logic             oe_n,
    output op_e              op,
    output logic [LANES-1:0] lane_we
);
    logic             sel;
    logic [LANES-1:0] lane_req;
    logic             is_write;

    assign sel = chip_selected(ce1_n, ce2_n, ce3);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_req[g] = !gw_n || (!bwe_n && !bw_n[g]);
    end

    assign is_write = sel && (|lane_req);
    assign lane_we  = is_write ? lane_req : '0;

    always_comb begin
        if (!sel)                 op = OP_DESEL;
        else if (is_write)        op = din_en_n ? OP_FILL : OP_WRITE;
        else if (!din_en_n && oe_n) op = OP_COMPARE;
        else                      op = OP_READ;
    end
endmodule

// File: rtl/tagram_array.sv
module tagram_array #(
    parameter int ADDR_W = 4,
    parameter int LANE_W = 9,
    parameter int LANES  = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [ADDR_W-1:0]         addr,
    input  logic [LANES-1:0]          lane_we,
    input  logic [LANES*LANE_W-1:0]   wdata,
    output logic [LANES*LANE_W-1:0]   rdata
);
    localparam int DEPTH  = 1 << ADDR_W;
    localparam int DATA_W = LANES * LANE_W;

    logic [DATA_W-1:0] mem [DEPTH];

    assign rdata = mem[addr];

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst) begin
                for (int w = 0; w < DEPTH; w++) begin
                    mem[w][g*LANE_W +: LANE_W] <= '0;
                end
            end else if (lane_we[g]) begin
                mem[addr][g*LANE_W +: LANE_W] <= wdata[g*LANE_W +: LANE_W];
            end
        end
    end
endmodule

// File: rtl/tagram_outctl.sv
module tagram_outctl
    import tagram_pkg::*;
#(
    parameter int DATA_W = 18
) (
    input  logic              clk,
    input  logic              rst,
    input  op_e               op,
    input  logic [DATA_W-1:0] rdata,
    input  logic [DATA_W-1:0] dq_i,
    input  logic              oe_n,
    input  logic              moe_n,
    output logic [DATA_W-1:0] dq_o,
    output logic              dq_oe,
    output logic              match_o,
    output logic              match_oe,
    output logic [DATA_W-1:0] cmp_word
);
    out_e              st_q;
    logic              hit_q;
    logic [DATA_W-1:0] dout_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q     <= OUT_NONE;
            hit_q    <= 1'b0;
            dout_q   <= '0;
            cmp_word <= '0;
        end else begin
            unique case (op)
                OP_READ: begin
                    st_q   <= OUT_READ;
                    dout_q <= rdata;
                end
                OP_COMPARE: begin
                    st_q     <= OUT_MATCH;
                    hit_q    <= (dq_i == rdata);
                    cmp_word <= dq_i;
                end
                OP_DESEL: st_q <= OUT_DESEL;
                default:  st_q <= OUT_NONE;
            endcase
        end
    end

    // enables are combinational in oe_n / moe_n: no clock between pin and driver
    assign dq_o     = dout_q;
    assign dq_oe    = (st_q == OUT_READ) && !oe_n;
    assign match_oe = !moe_n && ((st_q == OUT_MATCH) || (st_q == OUT_DESEL));
    assign match_o  = (st_q == OUT_MATCH) ? hit_q : 1'b1;
endmodule

// File: rtl/tagram_cmp.sv
module tagram_cmp
    import tagram_pkg::*;
#(
    parameter int ADDR_W = ADDR_W_DEF,
    parameter int LANE_W = LANE_W_DEF,
    parameter int LANES  = LANES_DEF
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    ce1_n,
    input  logic                    ce2_n,
    input  logic                    ce3,
    input  logic                    gw_n,
    input  logic                    bwe_n,
    input  logic [LANES-1:0]        bw_n,
    input  logic                    din_en_n,
    input  logic                    oe_n,
    input  logic                    moe_n,
    input  logic [LANES*LANE_W-1:0] dq_i,
    output logic [LANES*LANE_W-1:0] dq_o,
    output logic                    dq_oe,
    output logic                    match_o,
    output logic                    match_oe
);
    localparam int DATA_W = LANES * LANE_W;

    op_e               op;
    logic [LANES-1:0]  lane_we;
    logic [DATA_W-1:0] rdata;
    logic [DATA_W-1:0] wdata;
    logic [DATA_W-1:0] cmp_word;

    tagram_decode #(.LANES(LANES)) u_decode (
        .ce1_n    (ce1_n),
        .ce2_n    (ce2_n),
        .ce3      (ce3),
        .gw_n     (gw_n),
        .bwe_n    (bwe_n),
        .bw_n     (bw_n),
        .din_en_n (din_en_n),
        .oe_n     (oe_n),
        .op       (op),
        .lane_we  (lane_we)
    );

    // a fill takes the latched compare word instead of the bus
    assign wdata = (op == OP_FILL) ? cmp_word : dq_i;

    tagram_array #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_array (
        .clk     (clk),
        .rst     (rst),
        .addr    (addr),
        .lane_we (lane_we),
        .wdata   (wdata),
        .rdata   (rdata)
    );

    tagram_outctl #(.DATA_W(DATA_W)) u_outctl (
        .clk      (clk),
        .rst      (rst),
        .op       (op),
        .rdata    (rdata),
        .dq_i     (dq_i),
        .oe_n     (oe_n),
        .moe_n    (moe_n),
        .dq_o     (dq_o),
        .dq_oe    (dq_oe),
        .match_o  (match_o),
        .match_oe (match_oe),
        .cmp_word (cmp_word)
    );
endmodule

// File: rtl/tagram_cmp_sva.sv
module tagram_cmp_sva #(
    parameter int ADDR_W = 4,
    parameter int LANE_W = 9,
    parameter int LANES  = 2
) (
    input logic                    clk,
    input logic                    rst,
    input logic [ADDR_W-1:0]       addr,
    input logic                    ce1_n,
    input logic                    ce2_n,
    input logic                    ce3,
    input logic                    gw_n,
    input logic                    bwe_n,
    input logic [LANES-1:0]        bw_n,
    input logic                    din_en_n,
    input logic                    oe_n,
    input logic                    moe_n,
    input logic [LANES*LANE_W-1:0] dq_i,
    input logic [LANES*LANE_W-1:0] dq_o,
    input logic                    dq_oe,
    input logic                    match_o,
    input logic                    match_oe
);
    logic sel_c;
    logic we_c;
    logic rst_q;

    assign sel_c = !ce1_n && !ce2_n && ce3;
    assign we_c  = !gw_n || (!bwe_n && !(&bw_n));

    always_ff @(posedge clk) rst_q <= rst;

    always @(negedge clk) begin
        if (rst_q) begin
            assert_reset_quiet_R9: assert (!dq_oe && !match_oe)
                else $error("outputs driven during reset");
        end
    end

    assert_desel_match_high_R7: assert property (@(posedge clk) disable iff (rst)
        !sel_c |=> (match_o && !dq_oe));

    assert_oe_gates_bus_R8: assert property (@(posedge clk) disable iff (rst)
        oe_n |-> !dq_oe);

    assert_moe_gates_match_R8: assert property (@(posedge clk) disable iff (rst)
        moe_n |-> !match_oe);

    assert_fill_bus_quiet_R5: assert property (@(posedge clk) disable iff (rst)
        (sel_c && we_c && din_en_n) |=> !dq_oe);

    assert_compare_drives_R6: assert property (@(posedge clk) disable iff (rst)
        (sel_c && !we_c && !din_en_n && oe_n) |=> (match_oe || moe_n));

    assert_write_then_read_R4: assert property (@(posedge clk) disable iff (rst)
        (sel_c && !gw_n && !din_en_n) ##1 (sel_c && !we_c && !oe_n && addr == $past(addr))
        |=> (dq_o == $past(dq_i, 2)));
endmodule

bind tagram_cmp tagram_cmp_sva #(.ADDR_W(ADDR_W), .LANE_W(LANE_W), .LANES(LANES)) u_sva (
    .clk      (clk),
    .rst      (rst),
    .addr     (addr),
    .ce1_n    (ce1_n),
    .ce2_n    (ce2_n),
    .ce3      (ce3),
    .gw_n     (gw_n),
    .bwe_n    (bwe_n),
    .bw_n     (bw_n),
    .din_en_n (din_en_n),
    .oe_n     (oe_n),
    .moe_n    (moe_n),
    .dq_i     (dq_i),
    .dq_o     (dq_o),
    .dq_oe    (dq_oe),
    .match_o  (match_o),
    .match_oe (match_oe)
);

// File: tb/tagram_cmp_tb.sv
module tagram_cmp_tb;
    timeunit 1ns;
    timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  addr;
    logic        ce1_n, ce2_n, ce3;
    logic        gw_n, bwe_n;
    logic [1:0]  bw_n;
    logic        din_en_n, oe_n, moe_n;
    logic [17:0] dq_i;
    logic [17:0] dq_o;
    logic        dq_oe, match_o, match_oe;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    tagram_cmp u_dut (
        .clk(clk), .rst(rst), .addr(addr),
        .ce1_n(ce1_n), .ce2_n(ce2_n), .ce3(ce3),
        .gw_n(gw_n), .bwe_n(bwe_n), .bw_n(bw_n),
        .din_en_n(din_en_n), .oe_n(oe_n), .moe_n(moe_n),
        .dq_i(dq_i), .dq_o(dq_o), .dq_oe(dq_oe),
        .match_o(match_o), .match_oe(match_oe)
    );

    // vector: kind(2) addr(4) data(18) expect(18); kind 0 write, 1 read, 2 compare, 3 fill
    typedef logic [41:0] vec_t;
    localparam int NVEC = 16;
    localparam vec_t VECS [NVEC] = '{
        {2'd0, 4'd0,  18'h3FFFF, 18'h0},
        {2'd0, 4'd1,  18'h12345, 18'h0},
        {2'd0, 4'd15, 18'h2AAAA, 18'h0},
        {2'd1, 4'd0,  18'h0,     18'h3FFFF},
        {2'd1, 4'd1,  18'h0,     18'h12345},
        {2'd1, 4'd15, 18'h0,     18'h2AAAA},
        {2'd2, 4'd1,  18'h12345, 18'h1},
        {2'd2, 4'd1,  18'h12344, 18'h0},
        {2'd3, 4'd2,  18'h0,     18'h0},
        {2'd1, 4'd2,  18'h0,     18'h12344},
        {2'd2, 4'd15, 18'h2AAAA, 18'h1},
        {2'd3, 4'd3,  18'h0,     18'h0},
        {2'd1, 4'd3,  18'h0,     18'h2AAAA},
        {2'd2, 4'd0,  18'h1FFFF, 18'h0},
        {2'd2, 4'd3,  18'h2AAAA, 18'h1},
        {2'd1, 4'd4,  18'h0,     18'h0}
    };

    task automatic chk(input bit ok, input string tag, input logic [17:0] act, input logic [17:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic defaults();
        ce1_n = 1'b0; ce2_n = 1'b0; ce3 = 1'b1;
        gw_n = 1'b1; bwe_n = 1'b1; bw_n = 2'b11;
        din_en_n = 1'b1; oe_n = 1'b1; moe_n = 1'b1;
        dq_i = '0; addr = '0;
    endtask

    task automatic wr(input logic [3:0] a, input logic [17:0] d);
        @(negedge clk); defaults();
        addr = a; gw_n = 1'b0; din_en_n = 1'b0; dq_i = d;
        @(posedge clk); #1;
    endtask

    task automatic bwr(input logic [3:0] a, input logic [1:0] lanes_n, input logic [17:0] d);
        @(negedge clk); defaults();
        addr = a; bwe_n = 1'b0; bw_n = lanes_n; din_en_n = 1'b0; dq_i = d;
        @(posedge clk); #1;
    endtask

    task automatic rd(input logic [3:0] a, input logic [17:0] e, input string tag);
        @(negedge clk); defaults();
        addr = a; oe_n = 1'b0;
        @(posedge clk); #1;
        chk(dq_oe === 1'b1 && dq_o === e, tag, dq_o, e);
    endtask

    task automatic cmp(input logic [3:0] a, input logic [17:0] d, input logic e, input string tag);
        @(negedge clk); defaults();
        addr = a; din_en_n = 1'b0; moe_n = 1'b0; dq_i = d;
        @(posedge clk); #1;
        chk(match_oe === 1'b1 && match_o === e, tag, {17'h0, match_o}, {17'h0, e});
    endtask

    task automatic fill(input logic [3:0] a, input logic [1:0] lanes_n, input bit use_gw);
        @(negedge clk); defaults();
        addr = a; din_en_n = 1'b1; oe_n = 1'b0;
        if (use_gw) gw_n = 1'b0;
        else begin bwe_n = 1'b0; bw_n = lanes_n; end
        @(posedge clk); #1;
        chk(dq_oe === 1'b0, "R5 fill leaves bus undriven", {17'h0, dq_oe}, 18'h0);
    endtask

    task automatic desel(input logic e1_n, input logic e2_n, input logic e3);
        @(negedge clk); defaults();
        ce1_n = e1_n; ce2_n = e2_n; ce3 = e3;
        addr = 4'd5; gw_n = 1'b0; din_en_n = 1'b0; dq_i = 18'h30F0F;
        oe_n = 1'b0; moe_n = 1'b0;
        @(posedge clk); #1;
        chk(match_oe === 1'b1 && match_o === 1'b1 && dq_oe === 1'b0,
            "R1 R7 deselected drives match high, bus off",
            {15'h0, match_oe, match_o, dq_oe}, 18'h6);
    endtask

    initial begin
        #(200000 * 5);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        defaults();
        rst = 1'b1;
        oe_n = 1'b0; moe_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        chk(dq_oe === 1'b0 && match_oe === 1'b0, "R9 outputs off in reset",
            {16'h0, dq_oe, match_oe}, 18'h0);
        @(negedge clk); rst = 1'b0; defaults();
        rd(4'd0, 18'h0, "R9 memory cleared");
        fill(4'd10, 2'b00, 1'b1);
        rd(4'd10, 18'h0, "R9 compare word cleared");

        // table walk: R3 reads, R4 writes, R6 compares, R5 fills
        for (int i = 0; i < NVEC; i++) begin
            vec_t v;
            v = VECS[i];
            case (v[41:40])
                2'd0: wr(v[39:36], v[35:18]);
                2'd1: rd(v[39:36], v[17:0], "R3 R4 R5 table read");
                2'd2: cmp(v[39:36], v[35:18], v[0], "R6 table compare");
                default: fill(v[39:36], 2'b00, 1'b1);
            endcase
        end

        // R1: each enable failing alone blocks the write
        desel(1'b1, 1'b0, 1'b1);
        desel(1'b0, 1'b1, 1'b1);
        desel(1'b0, 1'b0, 1'b0);
        rd(4'd5, 18'h0, "R1 deselected write ignored");

        // R7: deselected with moe_n high leaves match undriven
        @(negedge clk); defaults(); ce3 = 1'b0;
        @(posedge clk); #1;
        chk(match_oe === 1'b0 && match_o === 1'b1, "R7 deselect moe high",
            {16'h0, match_oe, match_o}, 18'h1);

        // R2: byte lanes
        wr(4'd6, 18'h3FFFF);
        bwr(4'd6, 2'b10, 18'h0);
        rd(4'd6, 18'h3FE00, "R2 lane0 only");
        bwr(4'd6, 2'b01, 18'h0);
        rd(4'd6, 18'h0, "R2 lane1 only");
        bwr(4'd6, 2'b11, 18'h3FFFF);
        rd(4'd6, 18'h0, "R2 no lane selected");
        @(negedge clk); defaults(); addr = 4'd6; bw_n = 2'b00; din_en_n = 1'b0; dq_i = 18'h3FFFF;
        @(posedge clk); #1;
        rd(4'd6, 18'h0, "R2 lanes without bwe");

        // R6: match not driven during a read cycle
        @(negedge clk); defaults(); addr = 4'd1; oe_n = 1'b0; moe_n = 1'b0;
        @(posedge clk); #1;
        chk(match_oe === 1'b0, "R6 read does not drive match", {17'h0, match_oe}, 18'h0);

        // R8: async data output enable on a held read
        rd(4'd1, 18'h12345, "R8 read before toggle");
        oe_n = 1'b1; #1;
        chk(dq_oe === 1'b0, "R8 oe_n high turns bus off", {17'h0, dq_oe}, 18'h0);
        oe_n = 1'b0; #1;
        chk(dq_oe === 1'b1, "R8 oe_n low turns bus on", {17'h0, dq_oe}, 18'h1);

        // R8 R6: compare with moe_n high, then lower it without a clock
        @(negedge clk); defaults(); addr = 4'd1; din_en_n = 1'b0; dq_i = 18'h12345;
        @(posedge clk); #1;
        chk(match_oe === 1'b0, "R6 moe high keeps match off", {17'h0, match_oe}, 18'h0);
        moe_n = 1'b0; #1;
        chk(match_oe === 1'b1 && match_o === 1'b1, "R8 moe low drives match",
            {16'h0, match_oe, match_o}, 18'h3);

        // R10: only compare cycles load the fill word
        cmp(4'd4, 18'h00ABC, 1'b0, "R10 compare loads word");
        wr(4'd7, 18'h11111);
        rd(4'd7, 18'h11111, "R4 write then read");
        fill(4'd8, 2'b00, 1'b1);
        rd(4'd8, 18'h00ABC, "R10 fill uses compare word");
        fill(4'd9, 2'b10, 1'b0);
        rd(4'd9, 18'h000BC, "R5 fill honours lane mask");

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule